// File: doc/BRIEF.md
# Comparator Control and Interrupt Logic

This block is the digital side of one analog voltage comparator inside a microcontroller. Software writes a single control byte. The byte holds an enable bit, a 3-bit reference-select code, an output-enable bit and an edge-select bit. From these bits the block decides which of the three comparator pins (positive input, negative input, output) belong to the comparator and which stay ordinary GPIO. It also drives the reference-select code sent to the analog divider.

The comparator result arrives asynchronously. The block passes it through a synchronizer and shows it as a live status bit in the read-back byte. It can also drive the result onto the output pin. A sticky interrupt flag is set on the edge that software selects. Software clears the flag by writing 1 to its bit position.

Top module: `cmp_ctrl`

## Requirements
- R1: After reset, all control bits are 0, the interrupt flag is 0 and the read-back byte `rdata_o` is 0x00.
- R2: While enable (bit 0) is 0, `cmp_en_o`, `neg_sel_o`, `pos_sel_o` and `out_sel_o` are 0 and `ref_sel_o` is 000. The status bit reads 0. No change of `cmp_raw_i` sets the interrupt flag.
- R3: While enable is 1, `cmp_en_o` and `neg_sel_o` are 1, so the negative-input pin belongs to the comparator.
- R4: The reference code is control bits [3:1].
  - With enable set and code 000, `pos_sel_o` is 1 and `ref_sel_o` is 000, so the positive-input pin is used.
  - With enable set and codes 001 to 111, `pos_sel_o` is 0 and `ref_sel_o` equals the code. The codes select 0.2 to 0.8 of Vdd in steps of 0.1, in ascending order.
- R5: With enable and output-enable (bit 4) both 1, `out_sel_o` is 1 and `out_data_o` follows the status bit. Otherwise `out_sel_o` and `out_data_o` are 0.
- R6: The status bit (bit 7, read-only) follows `cmp_raw_i` without latching, after exactly two rising clock edges of synchronization.
- R7: The edge-select bit is bit 5.
  - With edge-select 0, a high-to-low change of the synchronized result sets the interrupt flag.
  - With edge-select 1, a low-to-high change sets it.
  - The opposite edge never sets the flag.
- R8: The interrupt flag is bit 6 and also drives `irq_o`. It stays set until software writes 1 to bit 6. A write with bit 6 at 0 leaves the flag unchanged.
- R9: When a set event and a clearing write fall in the same cycle, the flag ends up set.
- R10: Enabling the comparator while its result is already high (or low) does not set the flag for either edge selection. Only a change seen after valid samples exist sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wdata_i | input | 8 | Write data: [0] enable, [3:1] reference code, [4] output enable, [5] edge select, [6] write 1 to clear the flag |
| rdata_o | output | 8 | Read-back: control bits, [6] interrupt flag, [7] live status |
| cmp_raw_i | input | 1 | Asynchronous comparator result |
| cmp_en_o | output | 1 | Analog comparator enable |
| neg_sel_o | output | 1 | Negative-input pin routed to the comparator |
| pos_sel_o | output | 1 | Positive-input pin routed to the comparator |
| ref_sel_o | output | 3 | Reference code for the divider (000 means pin input) |
| out_sel_o | output | 1 | Output pin driven by the comparator, GPIO isolated |
| out_data_o | output | 1 | Value driven onto the output pin |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
A vector table runs every pair of start and end levels of the comparator result under both edge selections. This separates a correct edge polarity from an inverted one and shows that the opposite edge or a steady level never sets the flag.

Directed sequences do the following:
- sweep all eight reference codes with the comparator disabled and enabled;
- measure the two-edge status latency;
- make a clearing write meet a set event in the same cycle;
- re-enable the comparator while its result is high, to expose a false edge produced by reset-state synchronizer contents.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned REF_W    = 3;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_REF  = 1;
  localparam int unsigned BIT_OEN  = 4;
  localparam int unsigned BIT_ESEL = 5;
  localparam int unsigned BIT_IRQ  = 6;
  localparam int unsigned BIT_STAT = 7;

  typedef struct packed {
    logic             esel;
    logic             oen;
    logic [REF_W-1:0] ref_code;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
  import cmp_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              clr_o
);
  logic unused_wdata;
  assign unused_wdata = wdata_i[BIT_STAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (wr_en_i) begin
      ctrl_o.en       <= wdata_i[BIT_EN];
      ctrl_o.ref_code <= wdata_i[BIT_REF +: REF_W];
      ctrl_o.oen      <= wdata_i[BIT_OEN];
      ctrl_o.esel     <= wdata_i[BIT_ESEL];
    end
  end

  assign clr_o = wr_en_i & wdata_i[BIT_IRQ];
endmodule

// File: rtl/cmp_ctrl_sync.sv
module cmp_ctrl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic raw_i,
  output logic smp_o,
  output logic vld_o
);
  logic [STAGES-1:0] smp_q;
  logic [STAGES-1:0] vld_q;

  // samples and their validity move together; disable flushes both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      vld_q <= '0;
    end else if (!en_i) begin
      smp_q <= '0;
      vld_q <= '0;
    end else begin
      smp_q <= {smp_q[STAGES-2:0], raw_i};
      vld_q <= {vld_q[STAGES-2:0], 1'b1};
    end
  end

  assign smp_o = smp_q[STAGES-1] & en_i;
  assign vld_o = vld_q[STAGES-1] & en_i;
endmodule

// File: rtl/cmp_ctrl_edge.sv
module cmp_ctrl_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic vld_i,
  input  logic rise_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q;
  logic prev_vld_q;
  logic hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= 1'b0;
      prev_vld_q <= 1'b0;
    end else begin
      prev_q     <= smp_i;
      prev_vld_q <= vld_i;
    end
  end

  assign hit = vld_i & prev_vld_q &
               (rise_i ? (smp_i & ~prev_q) : (~smp_i & prev_q));

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (hit)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cmp_raw_i,
  output logic              cmp_en_o,
  output logic              neg_sel_o,
  output logic              pos_sel_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic              out_sel_o,
  output logic              out_data_o,
  output logic              irq_o
);
  ctrl_t ctrl;
  logic  clr;
  logic  smp;
  logic  vld;

  cmp_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl),
    .clr_o   (clr)
  );

  cmp_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.en),
    .raw_i  (cmp_raw_i),
    .smp_o  (smp),
    .vld_o  (vld)
  );

  cmp_ctrl_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (smp),
    .vld_i  (vld),
    .rise_i (ctrl.esel),
    .clr_i  (clr),
    .flag_o (irq_o)
  );

  assign cmp_en_o   = ctrl.en;
  assign neg_sel_o  = ctrl.en;
  assign pos_sel_o  = ctrl.en & (ctrl.ref_code == '0);
  assign ref_sel_o  = ctrl.en ? ctrl.ref_code : '0;
  assign out_sel_o  = ctrl.en & ctrl.oen;
  assign out_data_o = out_sel_o & smp;

  always_comb begin
    rdata_o                      = '0;
    rdata_o[BIT_EN]              = ctrl.en;
    rdata_o[BIT_REF +: REF_W]    = ctrl.ref_code;
    rdata_o[BIT_OEN]             = ctrl.oen;
    rdata_o[BIT_ESEL]            = ctrl.esel;
    rdata_o[BIT_IRQ]             = irq_o;
    rdata_o[BIT_STAT]            = smp;
  end
endmodule

// File: rtl/cmp_ctrl_chk.sv
module cmp_ctrl_chk
  import cmp_ctrl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              cmp_raw_i,
  input logic              cmp_en_o,
  input logic              neg_sel_o,
  input logic              pos_sel_o,
  input logic [REF_W-1:0]  ref_sel_o,
  input logic              out_sel_o,
  input logic              out_data_o,
  input logic              irq_o
);
  logic unused_chk;
  assign unused_chk = cmp_raw_i ^ cmp_en_o;

  // R2
  a_r2_disabled_gpio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[BIT_EN] |-> !neg_sel_o && !pos_sel_o && !out_sel_o && !rdata_o[BIT_STAT]);

  // R4
  a_r4_pin_or_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_sel_o |-> ref_sel_o == '0);

  // R5
  a_r5_drive_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_data_o |-> out_sel_o && rdata_o[BIT_STAT]);

  // R7
  a_r7_edge_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(rdata_o[BIT_STAT]) != $past(rdata_o[BIT_STAT], 2)) &&
                     ($past(rdata_o[BIT_STAT]) == $past(rdata_o[BIT_ESEL])));

  // R8
  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(wr_en_i && wdata_i[BIT_IRQ]) |=> irq_o);
endmodule

bind cmp_ctrl cmp_ctrl_chk u_chk (.*);

// File: tb/cmp_ctrl_tb_top.sv
module cmp_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic       cmp_raw_i = 1'b0;
  logic [7:0] rdata_o;
  logic       cmp_en_o, neg_sel_o, pos_sel_o, out_sel_o, out_data_o, irq_o;
  logic [2:0] ref_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cmp_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .cmp_raw_i(cmp_raw_i), .cmp_en_o(cmp_en_o),
    .neg_sel_o(neg_sel_o), .pos_sel_o(pos_sel_o), .ref_sel_o(ref_sel_o),
    .out_sel_o(out_sel_o), .out_data_o(out_data_o), .irq_o(irq_o)
  );

  // {edge_sel, raw_from, raw_to, expected irq}
  localparam logic [3:0] VEC [8] = '{
    4'b0_10_1, 4'b0_01_0, 4'b0_00_0, 4'b0_11_0,
    4'b1_01_1, 4'b1_10_0, 4'b1_00_0, 4'b1_11_0
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wdata_i = 8'h00;
  endtask

  initial begin
    logic [7:0] ctl;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R1 rdata after reset", rdata_o, 8'h00);
    chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);

    // R2 / R4 disabled: every code, routing stays GPIO
    for (int c = 0; c < 8; c++) begin
      wr({4'b0000, c[2:0], 1'b0});
      chk("R2 routing while disabled",
          {2'd0, cmp_en_o, neg_sel_o, pos_sel_o, ref_sel_o}, 8'h00);
    end
    // R3 / R4 enabled sweep
    for (int c = 0; c < 8; c++) begin
      wr({4'b0000, c[2:0], 1'b1});
      chk("R3 comparator owns negative pin", {6'd0, cmp_en_o, neg_sel_o}, 8'h03);
      chk("R4 pos pin select", {7'd0, pos_sel_o}, {7'd0, c == 0});
      chk("R4 reference code", {5'd0, ref_sel_o}, (c == 0) ? 8'h00 : c[7:0]);
    end

    // R7 vector table walk
    for (int i = 0; i < 8; i++) begin
      ctl = {2'b00, VEC[i][3], 1'b0, 3'b000, 1'b1};
      wr(ctl | 8'h40);
      cmp_raw_i = VEC[i][2];
      cyc(5);
      wr(ctl | 8'h40);
      chk("R7 flag clear before vector", {7'd0, irq_o}, 8'h00);
      cmp_raw_i = VEC[i][1];
      cyc(5);
      chk("R7 edge flag", {7'd0, irq_o}, {7'd0, VEC[i][0]});
      chk("R6 status settled", {7'd0, rdata_o[7]}, {7'd0, VEC[i][1]});
    end

    // R6 latency: raw 0 -> 1
    ctl = 8'h31;  // enable, output enable, rising edge
    wr(ctl | 8'h40);
    cmp_raw_i = 1'b0;
    cyc(5);
    wr(ctl | 8'h40);
    cmp_raw_i = 1'b1;
    cyc(1);
    chk("R6 status after one edge", {7'd0, rdata_o[7]}, 8'h00);
    cyc(1);
    chk("R6 status after two edges", {7'd0, rdata_o[7]}, 8'h01);
    chk("R5 output pin driven", {6'd0, out_sel_o, out_data_o}, 8'h03);
    cyc(3);
    // R8 write 0 keeps flag, write 1 clears
    chk("R8 flag set by rise", {7'd0, irq_o}, 8'h01);
    wr(ctl);
    chk("R8 write 0 keeps flag", {7'd0, rdata_o[6]}, 8'h01);
    wr(ctl | 8'h40);
    chk("R8 write 1 clears flag", {7'd0, irq_o}, 8'h00);
    wr(8'h21);  // output enable off
    chk("R5 output pin GPIO", {6'd0, out_sel_o, out_data_o}, 8'h00);

    // R9 set and clear in the same cycle
    ctl = 8'h21;
    cmp_raw_i = 1'b0;
    cyc(5);
    wr(ctl | 8'h40);
    chk("R9 flag clear before race", {7'd0, irq_o}, 8'h00);
    cmp_raw_i = 1'b1;
    cyc(2);
    wr_en_i = 1'b1;
    wdata_i = ctl | 8'h40;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wdata_i = 8'h00;
    chk("R9 set wins over clear", {7'd0, irq_o}, 8'h01);
    wr(ctl | 8'h40);

    // R2 disabled: toggles ignored
    wr(8'h00);
    for (int k = 0; k < 4; k++) begin
      cmp_raw_i = ~cmp_raw_i;
      cyc(4);
    end
    chk("R2 no flag while disabled", {7'd0, irq_o}, 8'h00);
    chk("R2 status 0 while disabled", {7'd0, rdata_o[7]}, 8'h00);

    // R10 re-enable with raw high, rising selected
    cmp_raw_i = 1'b1;
    cyc(2);
    wr(8'h21);
    cyc(6);
    chk("R10 no false flag on enable", {7'd0, irq_o}, 8'h00);
    chk("R10 status valid after enable", {7'd0, rdata_o[7]}, 8'h01);
    // R10 re-enable with raw low, falling selected
    wr(8'h00);
    cmp_raw_i = 1'b0;
    cyc(2);
    wr(8'h01);
    cyc(6);
    chk("R10 no false falling flag", {7'd0, irq_o}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule